// File: doc/BRIEF.md
# Phase-Sliced Virtual-Channel Allocator

This block assigns output virtual channels to head flits in a router whose virtual channels are split into isolated traffic domains. Each of the NPORT input ports carries NDOM domains of VPD channels. In any cycle a phase input names the one domain that may allocate. Only that domain's VPD channels at each input can request, and they can only receive output channels of the same domain. This makes the allocator NPORT·VPD wide instead of NPORT·NDOM·VPD wide, and it is shared over time by all domains.

Allocation runs in two round-robin rounds. In the first round each requesting input channel picks one output channel of its domain at the output port it asks for. The picked channel must be unallocated and have credit. In the second round each output channel grants one of the input channels that picked it. Every arbiter keeps a separate pointer for each domain, and the phase selects which pointer is read and updated. Load in one domain can therefore never shift a decision in another domain. The block also records which output channels are held, per domain, until the upstream logic reports that the packet's tail has left. Grants are registered, so they appear one cycle after the request, when the switch-allocation phase serves the same domain.

Top module: `vc_alloc_phased`

## Requirements
- R1: During and after a synchronous active-high reset, `gnt_valid` is all zero, `gnt_dom` is zero, every output channel is unallocated and every round-robin pointer is at index 0.
- R2: A request presented while `phase_va` = d produces its grant on `gnt_valid` in the following cycle, and `gnt_dom` then equals d. Input channel i is local channel v of input port p, with i = p·VPD + v.
- R3: A grant names, in `gnt_ovc` field i (bits i·MW and up), the local index w of an output channel of the active domain at the requested port. That channel is unallocated and has its credit bit set. The credit bit of port o, domain d, channel w is `ovc_credit_ok[o·NDOM·VPD + d·VPD + w]`.
- R4: In the first round, an input channel takes the first eligible output channel at or after its own pointer for the active domain. That pointer moves to one past the chosen channel only when the input channel is finally granted.
- R5: In the second round, an output channel picked by several input channels grants exactly one of them: the first at or after its pointer for the active domain, in ascending i order. That pointer then moves to one past the winner.
- R6: Pointers and allocation flags of domains other than the active one are neither read nor changed.
- R7: A granted output channel stays allocated in its domain and cannot be granted again until `rel_valid` names it (port `rel_port`, domain `rel_dom`, local index `rel_vc`). From the cycle after the release it is eligible again.
- R8: A request whose port field is NPORT or larger is ignored: no grant and no state change.
- R9: A request with no eligible output channel gets no grant and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_va | input | DW | Domain served by the allocation stage this cycle |
| req_valid | input | NPORT·VPD | Request flag per input channel of the active domain |
| req_port | input | NPORT·VPD·PW | Requested output port per input channel |
| ovc_credit_ok | input | NPORT·NDOM·VPD | Output channel has at least one buffer credit |
| rel_valid | input | 1 | Tail flit left; free the named output channel |
| rel_port | input | PW | Port of the channel to free |
| rel_dom | input | DW | Domain of the channel to free |
| rel_vc | input | MW | Local index of the channel to free |
| gnt_valid | output | NPORT·VPD | Registered grant per input channel |
| gnt_ovc | output | NPORT·VPD·MW | Registered local output-channel index per input channel |
| gnt_dom | output | DW | Domain the registered grants belong to |

## Verification
A pointer that sits wrong shows up as a different `gnt_ovc` index or a different winning input on the next contended request in that domain. The directed sequences are built so that a pointer shared between domains, or one that never advances, changes a grant within one or two requests. An allocation flag that fails to set shows as a second grant of a held channel on the very next request. A flag that fails to clear shows as a missing grant in the cycle after a release. A flag kept in the wrong domain shows when another domain's request for the same port comes back busy.

// File: rtl/vca_pkg.sv
package vca_pkg;
  // width of an index able to address n items (at least one bit)
  function automatic int unsigned idx_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rr_arb_dom.sv
module rr_arb_dom
  import vca_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int NDOM  = 4,
  localparam int IW   = idx_w(WIDTH),
  localparam int DW   = idx_w(NDOM)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DW-1:0]    dom,
  input  logic [WIDTH-1:0] req,
  input  logic             adv,
  output logic             gnt_any,
  output logic [IW-1:0]    gnt_idx
);
  logic [IW-1:0] ptr_q [NDOM];

  always_comb begin
    gnt_any = 1'b0;
    gnt_idx = '0;
    for (int k = 0; k < WIDTH; k++) begin
      int j;
      j = (int'(ptr_q[dom]) + k) % WIDTH;
      if (!gnt_any && req[j]) begin
        gnt_any = 1'b1;
        gnt_idx = IW'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int d = 0; d < NDOM; d++) ptr_q[d] <= '0;
    end else if (adv && gnt_any) begin
      ptr_q[dom] <= (int'(gnt_idx) == WIDTH - 1) ? '0 : gnt_idx + IW'(1);
    end
  end

  for (genvar d = 0; d < NDOM; d++) begin : g_chk
    p_ptr_range_r4: assert property (@(posedge clk) disable iff (rst)
      int'(ptr_q[d]) < WIDTH);
    p_ptr_other_dom_r6: assert property (@(posedge clk) disable iff (rst)
      (dom != DW'(d)) |=> $stable(ptr_q[d]));
  end
endmodule

// File: rtl/vca_busy_tbl.sv
module vca_busy_tbl
  import vca_pkg::*;
#(
  parameter int NPORT = 3,
  parameter int NDOM  = 4,
  parameter int VPD   = 2,
  localparam int V    = NDOM * VPD,
  localparam int TOT  = NPORT * V,
  localparam int NOUT = NPORT * VPD,
  localparam int PW   = idx_w(NPORT),
  localparam int DW   = idx_w(NDOM),
  localparam int MW   = idx_w(VPD)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DW-1:0]   dom,
  input  logic [NOUT-1:0] set_vec,
  input  logic            rel_valid,
  input  logic [PW-1:0]   rel_port,
  input  logic [DW-1:0]   rel_dom,
  input  logic [MW-1:0]   rel_vc,
  output logic [NOUT-1:0] busy_act
);
  logic [TOT-1:0] busy_q;
  logic           dom_ok;
  logic           rel_ok;
  int             rel_idx;
  logic           rel_clash;

  assign dom_ok = int'(dom) < NDOM;
  assign rel_ok = rel_valid && (int'(rel_port) < NPORT) && (int'(rel_dom) < NDOM)
                  && (int'(rel_vc) < VPD);

  always_comb begin
    for (int o = 0; o < NPORT; o++) begin
      for (int w = 0; w < VPD; w++) begin
        int b;
        b = dom_ok ? (o * V + int'(dom) * VPD + w) : 0;
        busy_act[o * VPD + w] = dom_ok ? busy_q[b] : 1'b1;
      end
    end
  end

  always_comb begin
    rel_idx   = rel_ok ? (int'(rel_port) * V + int'(rel_dom) * VPD + int'(rel_vc)) : 0;
    rel_clash = rel_ok && (rel_dom == dom)
                && set_vec[int'(rel_port) * VPD + int'(rel_vc)];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= '0;
    end else begin
      if (rel_ok) busy_q[rel_idx] <= 1'b0;
      if (dom_ok) begin
        for (int j = 0; j < NOUT; j++) begin
          if (set_vec[j]) busy_q[(j / VPD) * V + int'(dom) * VPD + (j % VPD)] <= 1'b1;
        end
      end
    end
  end

  p_set_only_free_r7: assert property (@(posedge clk) disable iff (rst)
    (set_vec & busy_act) == '0);
  p_release_frees_r7: assert property (@(posedge clk) disable iff (rst)
    (rel_ok && !rel_clash) |=> !busy_q[$past(rel_idx)]);
endmodule

// File: rtl/vc_alloc_phased.sv
module vc_alloc_phased
  import vca_pkg::*;
#(
  parameter int NPORT = 3,
  parameter int NDOM  = 4,
  parameter int VPD   = 2,
  localparam int V    = NDOM * VPD,
  localparam int NIN  = NPORT * VPD,
  localparam int PW   = idx_w(NPORT),
  localparam int DW   = idx_w(NDOM),
  localparam int MW   = idx_w(VPD),
  localparam int XW   = idx_w(NIN)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DW-1:0]       phase_va,
  input  logic [NIN-1:0]      req_valid,
  input  logic [NIN*PW-1:0]   req_port,
  input  logic [NPORT*V-1:0]  ovc_credit_ok,
  input  logic                rel_valid,
  input  logic [PW-1:0]       rel_port,
  input  logic [DW-1:0]       rel_dom,
  input  logic [MW-1:0]       rel_vc,
  output logic [NIN-1:0]      gnt_valid,
  output logic [NIN*MW-1:0]   gnt_ovc,
  output logic [DW-1:0]       gnt_dom
);
  logic              phase_ok;
  logic [NIN-1:0]    in_pok;
  logic [NIN-1:0]    busy_act;
  logic [NIN-1:0]    s1_any;
  logic [NIN*MW-1:0] s1_idx;
  logic [NIN-1:0]    s2_any;
  logic [NIN*XW-1:0] s2_idx;
  logic [NIN-1:0]    fin_gnt;

  assign phase_ok = int'(phase_va) < NDOM;

  // first round: one arbiter per input channel over its domain's VPD output channels
  for (genvar i = 0; i < NIN; i++) begin : g_s1
    logic [PW-1:0]  port_i;
    logic [VPD-1:0] cand;
    assign port_i    = req_port[i*PW +: PW];
    assign in_pok[i] = phase_ok && (int'(port_i) < NPORT);

    always_comb begin
      for (int w = 0; w < VPD; w++) begin
        int oi;
        int ci;
        oi = in_pok[i] ? int'(port_i) * VPD + w : 0;
        ci = in_pok[i] ? int'(port_i) * V + int'(phase_va) * VPD + w : 0;
        cand[w] = req_valid[i] && in_pok[i] && !busy_act[oi] && ovc_credit_ok[ci];
      end
    end

    rr_arb_dom #(.WIDTH(VPD), .NDOM(NDOM)) u_arb (
      .clk     (clk),
      .rst     (rst),
      .dom     (phase_va),
      .req     (cand),
      .adv     (fin_gnt[i]),
      .gnt_any (s1_any[i]),
      .gnt_idx (s1_idx[i*MW +: MW])
    );
  end

  // second round: one arbiter per output channel of the active domain over all inputs
  for (genvar j = 0; j < NIN; j++) begin : g_s2
    localparam int O = j / VPD;
    localparam int W = j % VPD;
    logic [NIN-1:0] req2;

    always_comb begin
      for (int i = 0; i < NIN; i++) begin
        req2[i] = s1_any[i] && in_pok[i]
                  && (int'(req_port[i*PW +: PW]) == O)
                  && (int'(s1_idx[i*MW +: MW]) == W);
      end
    end

    rr_arb_dom #(.WIDTH(NIN), .NDOM(NDOM)) u_arb (
      .clk     (clk),
      .rst     (rst),
      .dom     (phase_va),
      .req     (req2),
      .adv     (1'b1),
      .gnt_any (s2_any[j]),
      .gnt_idx (s2_idx[j*XW +: XW])
    );
  end

  always_comb begin
    fin_gnt = '0;
    for (int j = 0; j < NIN; j++) begin
      if (s2_any[j]) fin_gnt[int'(s2_idx[j*XW +: XW])] = 1'b1;
    end
  end

  vca_busy_tbl #(.NPORT(NPORT), .NDOM(NDOM), .VPD(VPD)) u_busy (
    .clk       (clk),
    .rst       (rst),
    .dom       (phase_va),
    .set_vec   (s2_any),
    .rel_valid (rel_valid),
    .rel_port  (rel_port),
    .rel_dom   (rel_dom),
    .rel_vc    (rel_vc),
    .busy_act  (busy_act)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_valid <= '0;
      gnt_ovc   <= '0;
      gnt_dom   <= '0;
    end else begin
      gnt_valid <= fin_gnt;
      gnt_dom   <= phase_va;
      for (int i = 0; i < NIN; i++) begin
        gnt_ovc[i*MW +: MW] <= fin_gnt[i] ? s1_idx[i*MW +: MW] : '0;
      end
    end
  end

  // checks across the two rounds and the allocation table
  logic clash;
  logic bad_credit;
  always_comb begin
    clash      = 1'b0;
    bad_credit = 1'b0;
    for (int i = 0; i < NIN; i++) begin
      if (fin_gnt[i] && !ovc_credit_ok[(in_pok[i] ? int'(req_port[i*PW +: PW]) * V
            + int'(phase_va) * VPD + int'(s1_idx[i*MW +: MW]) : 0)])
        bad_credit = 1'b1;
      for (int k = i + 1; k < NIN; k++) begin
        if (fin_gnt[i] && fin_gnt[k]
            && req_port[i*PW +: PW] == req_port[k*PW +: PW]
            && s1_idx[i*MW +: MW] == s1_idx[k*MW +: MW])
          clash = 1'b1;
      end
    end
  end

  p_unique_ovc_r5: assert property (@(posedge clk) disable iff (rst) !clash);
  p_grant_credit_r3: assert property (@(posedge clk) disable iff (rst) !bad_credit);
  p_grant_dom_r2: assert property (@(posedge clk) disable iff (rst)
    (|gnt_valid) |-> (gnt_dom == $past(phase_va)));

  for (genvar i = 0; i < NIN; i++) begin : g_chk
    p_grant_had_req_r2: assert property (@(posedge clk) disable iff (rst)
      gnt_valid[i] |-> $past(req_valid[i]));
    p_bad_port_ignored_r8: assert property (@(posedge clk) disable iff (rst)
      (req_valid[i] && !in_pok[i]) |=> !gnt_valid[i]);
  end
endmodule

// File: tb/sim_vc_alloc_phased.sv
module sim_vc_alloc_phased;
  localparam int NPORT = 3;
  localparam int NDOM  = 4;
  localparam int VPD   = 2;
  localparam int V     = NDOM * VPD;
  localparam int NIN   = NPORT * VPD;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [1:0]        phase_va = '0;
  logic [NIN-1:0]    req_valid = '0;
  logic [NIN*2-1:0]  req_port = '0;
  logic [NPORT*V-1:0] ovc_credit_ok = '1;
  logic              rel_valid = 1'b0;
  logic [1:0]        rel_port = '0;
  logic [1:0]        rel_dom = '0;
  logic [0:0]        rel_vc = '0;
  logic [NIN-1:0]    gnt_valid;
  logic [NIN-1:0]    gnt_ovc;
  logic [1:0]        gnt_dom;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  vc_alloc_phased #(.NPORT(NPORT), .NDOM(NDOM), .VPD(VPD)) u0 (
    .clk(clk), .rst(rst), .phase_va(phase_va), .req_valid(req_valid),
    .req_port(req_port), .ovc_credit_ok(ovc_credit_ok), .rel_valid(rel_valid),
    .rel_port(rel_port), .rel_dom(rel_dom), .rel_vc(rel_vc),
    .gnt_valid(gnt_valid), .gnt_ovc(gnt_ovc), .gnt_dom(gnt_dom)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put(int i, int p);
    req_valid[i] = 1'b1;
    req_port[i*2 +: 2] = 2'(p);
  endtask

  // present the staged requests for one cycle; grant visible at the next negedge
  task automatic fire(int d);
    phase_va = 2'(d);
    @(negedge clk);
    req_valid = '0;
  endtask

  task automatic release_vc(int p, int d, int w);
    rel_port = 2'(p); rel_dom = 2'(d); rel_vc = 1'(w); rel_valid = 1'b1;
    @(negedge clk);
    rel_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 gnt_valid after reset", int'(gnt_valid), 0);
    chk("R1 gnt_dom after reset", int'(gnt_dom), 0);
  endtask

  task automatic t_basic;
    put(0, 1); fire(0);
    chk("R2 grant next cycle", int'(gnt_valid), 'b000001);
    chk("R2 gnt_dom", int'(gnt_dom), 0);
    chk("R3 first free ovc", int'(gnt_ovc[0]), 0);
  endtask

  task automatic t_busy_skip;
    put(0, 1); fire(0);
    chk("R7 held ovc skipped valid", int'(gnt_valid), 'b000001);
    chk("R7 held ovc skipped idx", int'(gnt_ovc[0]), 1);
    put(0, 1); fire(0);
    chk("R9 none eligible", int'(gnt_valid), 0);
  endtask

  task automatic t_release;
    release_vc(1, 0, 0);
    put(0, 1); fire(0);
    chk("R7 released ovc granted valid", int'(gnt_valid), 'b000001);
    chk("R7 released ovc idx", int'(gnt_ovc[0]), 0);
  endtask

  task automatic t_other_domain;
    put(0, 1); fire(1);
    chk("R6 other domain valid", int'(gnt_valid), 'b000001);
    chk("R6 other domain dom", int'(gnt_dom), 1);
    chk("R6 other domain idx", int'(gnt_ovc[0]), 0);
  endtask

  task automatic t_credit;
    ovc_credit_ok[2*V + 2*VPD + 0] = 1'b0;
    put(1, 2); fire(2);
    ovc_credit_ok = '1;
    chk("R3 no-credit skipped valid", int'(gnt_valid), 'b000010);
    chk("R3 no-credit skipped idx", int'(gnt_ovc[1]), 1);
  endtask

  task automatic t_contention;
    put(0, 0); put(2, 0); put(4, 0); fire(3);
    chk("R5 single winner", int'(gnt_valid), 'b000001);
    chk("R5 winner idx", int'(gnt_ovc[0]), 0);
    // input 0 pointer in domain 3 moved; domain 2 pointer must be untouched
    put(0, 0); fire(2);
    chk("R6 pointer per domain valid", int'(gnt_valid), 'b000001);
    chk("R6 pointer per domain idx", int'(gnt_ovc[0]), 0);
    release_vc(0, 3, 0);
    put(0, 0); put(2, 0); put(4, 0); fire(3);
    chk("R5 rotated winners", int'(gnt_valid), 'b000101);
    chk("R4 input0 moved pointer", int'(gnt_ovc[0]), 1);
    chk("R4 input2 first free", int'(gnt_ovc[2]), 0);
    release_vc(0, 3, 0);
    release_vc(0, 3, 1);
    put(2, 0); put(4, 0); fire(3);
    chk("R5 both granted", int'(gnt_valid), 'b010100);
    chk("R4 input2 after advance", int'(gnt_ovc[2]), 1);
    chk("R4 input4 untouched", int'(gnt_ovc[4]), 0);
  endtask

  task automatic t_bad_port;
    put(5, 3); fire(2);
    chk("R8 bad port no grant", int'(gnt_valid), 0);
    put(5, 2); fire(2);
    chk("R8 state unchanged valid", int'(gnt_valid), 'b100000);
    chk("R8 state unchanged idx", int'(gnt_ovc[5]), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_busy_skip();
    t_release();
    t_other_domain();
    t_credit();
    t_contention();
    t_bad_port();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule